// File: doc/BRIEF.md
# Timeslot Test-Pattern Generator and Checker

This block injects a test pattern into chosen 8-bit timeslots of a framed, bit-serial stream of 32 timeslots and checks that pattern on the return path. On the transmit side, every bit of a selected timeslot is replaced by the next bit of the pattern. Every other bit passes through unchanged. The pattern is one of two maximal-length pseudo-random sequences, with periods 2^15-1 and 2^20-1, or a programmable fixed word of 1 to 32 bits that repeats.

On the receive side, the bits of the same selected timeslots are taken out of the stream and fed to a checker. The checker hunts for lock on the pattern, accepting either the true or the bit-inverted form, and reports which form it found. Once locked, it counts the bits it checks and the bits that disagree. It drops lock when errors become too dense. Framing is not done here. Each direction has a frame-start strobe that marks the first bit of timeslot 0, and the slot position is counted from that strobe. The block takes one bit per clock.

Top module: `ts_prbs_unit`

## Requirements
- R1: `cfg_mode` 2'b00 selects the x^15+x^14+1 sequence and 2'b01 selects the x^20+x^17+1 sequence. Both run as shift registers that move toward the MSB. The new bit is the XOR of state bits 14 and 13 (or bits 19 and 16), it is shifted in at bit 0, and it is also the transmitted bit. The register resets to all ones. If the bits in use are all zero, the register is first reloaded with all ones.
- R2: The bit that comes with `tx_fsync` is bit 0 of timeslot 0. Bit n of the 256-bit frame belongs to slot n/8, and `cfg_slot_mask` bit k selects slot k. `tx_out` shows, one clock later, either the pattern bit (selected slot) or `tx_in` (unselected slot). The receive side locates slots from `rx_fsync` in the same way.
- R3: When `cfg_mode[1]` is 1, the pattern sends `cfg_fixed` bit 0, then bit 1, and so on up to bit `cfg_fix_len`, and then starts again at bit 0. The pattern length is therefore `cfg_fix_len`+1.
- R4: `sync` rises after 32 consecutive selected receive bits that all agree with the expected pattern, either all true or all inverted. `sync_inv` is 1 when the lock is on the inverted pattern.
- R5: While `sync` is 1, each selected receive bit that differs from the expected pattern adds 1 to `err_count`.
- R6: `bit_count` adds 1 for each selected receive bit checked while `sync` is 1. It does not change while `sync` is 0.
- R7: The in-sync stream is divided into 64-bit windows, starting when lock is gained. `sync` drops on the 6th error within one window. Fewer errors in a window keep lock.
- R8: `sync_irq` is high for exactly the cycles in which `sync` has just changed value.
- R9: During reset, `sync`, `sync_inv`, `sync_irq`, `tx_out`, `err_count` and `bit_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Pattern type: 00 short sequence, 01 long sequence, 1x fixed word |
| cfg_fixed | input | 32 | Fixed pattern word, bit 0 sent first |
| cfg_fix_len | input | 5 | Fixed pattern length minus one |
| cfg_slot_mask | input | 32 | Timeslot selection, bit k for slot k |
| tx_fsync | input | 1 | Marks bit 0 of slot 0 on the transmit side |
| tx_in | input | 1 | Transmit stream in |
| tx_out | output | 1 | Transmit stream out, with the pattern inserted |
| rx_fsync | input | 1 | Marks bit 0 of slot 0 on the receive side |
| rx_in | input | 1 | Receive stream in |
| sync | output | 1 | Checker locked |
| sync_inv | output | 1 | Lock is on the inverted pattern |
| sync_irq | output | 1 | One-cycle pulse on each change of `sync` |
| err_count | output | 32 | Bit errors counted in sync |
| bit_count | output | 32 | Bits checked in sync |

## Verification
`tx_out` is due one clock after the edge that consumes the input bit. The bench computes the expected transmit bit when it drives the inputs, then compares after the following rising edge, on the falling edge. The counters, `sync` and `sync_irq` all change at the same edge that consumes a receive bit. So each check compares values sampled on one falling edge against values from the falling edge just before it. Count totals are compared as differences between two falling-edge snapshots, against the selected bits and injected errors that the bench tallied in between.

// File: rtl/ts_prbs_pkg.sv
package ts_prbs_pkg;

    localparam int LFSR_W = 20;

    typedef enum logic [1:0] {
        PAT_SHORT = 2'b00,
        PAT_LONG  = 2'b01,
        PAT_WORD  = 2'b10,
        PAT_WORD2 = 2'b11
    } pat_mode_e;

    // Feedback bit of the selected sequence
    function automatic logic lfsr_tap(input logic [LFSR_W-1:0] s, input logic [1:0] mode);
        logic t;
        if (mode == PAT_LONG) t = s[19] ^ s[16];
        else                  t = s[14] ^ s[13];
        return t;
    endfunction

    // True when the bits used by the selected sequence are all zero
    function automatic logic lfsr_dead(input logic [LFSR_W-1:0] s, input logic [1:0] mode);
        logic z;
        if (mode == PAT_LONG) z = (s == '0);
        else                  z = (s[14:0] == '0);
        return z;
    endfunction

endpackage

// File: rtl/ts_slot_track.sv
module ts_slot_track #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int FRAME    = SLOTS * SLOT_BITS,
    localparam int POS_W    = $clog2(FRAME),
    localparam int SB_W     = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [SLOTS-1:0] mask,
    output logic             active
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (fsync)                                 trk_d.pos = '0;
        else if (trk_q.pos == POS_W'(FRAME - 1))   trk_d.pos = '0;
        else                                       trk_d.pos = trk_q.pos + 1'b1;
        active = mask[trk_d.pos[POS_W-1:SB_W]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q.pos <= POS_W'(FRAME - 1);
        else        trk_q     <= trk_d;
    end

    AST_FSYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> trk_q.pos == '0); // R2

endmodule

// File: rtl/ts_pattern_gen.sv
module ts_pattern_gen
    import ts_prbs_pkg::*;
#(
    parameter int FIX_W  = 32,
    localparam int LEN_W = $clog2(FIX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             din,
    input  logic [1:0]       mode,
    input  logic [FIX_W-1:0] fixed,
    input  logic [LEN_W-1:0] len,
    output logic             dout
);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [LEN_W-1:0]  idx;
        logic              bit_o;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [LFSR_W-1:0] src;
    logic              fb;

    always_comb begin
        gen_d = gen_q;
        src   = lfsr_dead(gen_q.lfsr, mode) ? '1 : gen_q.lfsr;
        fb    = lfsr_tap(src, mode);
        if (active) begin
            if (mode[1]) begin
                gen_d.bit_o = fixed[gen_q.idx];
                gen_d.idx   = (gen_q.idx >= len) ? '0 : gen_q.idx + 1'b1;
            end else begin
                gen_d.lfsr  = {src[LFSR_W-2:0], fb};
                gen_d.bit_o = fb;
            end
        end else begin
            gen_d.bit_o = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q      <= '0;
            gen_q.lfsr <= '1;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign dout = gen_q.bit_o;

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> dout == $past(din)); // R2
    AST_GEN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !mode[1]) |=> !lfsr_dead(gen_q.lfsr, $past(mode))); // R1

endmodule

// File: rtl/ts_pattern_chk.sv
module ts_pattern_chk
    import ts_prbs_pkg::*;
#(
    parameter int FIX_W     = 32,
    parameter int CNT_W     = 32,
    parameter int SYNC_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 6,
    localparam int LEN_W    = $clog2(FIX_W),
    localparam int RUN_W    = $clog2(SYNC_RUN + 1),
    localparam int WB_W     = $clog2(WIN_LEN),
    localparam int WE_W     = $clog2(LOSS_ERRS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             din,
    input  logic [1:0]       mode,
    input  logic [FIX_W-1:0] fixed,
    input  logic [LEN_W-1:0] len,
    output logic             sync,
    output logic             inverted,
    output logic             irq,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] bit_cnt
);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [LEN_W-1:0]  idx;
        logic [RUN_W-1:0]  run;
        logic              pol;
        logic              locked;
        logic [WB_W-1:0]   wbits;
        logic [WE_W-1:0]   werrs;
        logic              irq;
        logic [CNT_W-1:0]  errc;
        logic [CNT_W-1:0]  bitc;
    } chk_t;

    chk_t chk_d, chk_q;
    logic             exp_raw;
    logic             diff;
    logic             bad;
    logic [LEN_W-1:0] idx_nx;
    logic [WE_W-1:0]  werrs_inc;

    always_comb begin
        chk_d     = chk_q;
        exp_raw   = mode[1] ? fixed[chk_q.idx] : lfsr_tap(chk_q.lfsr, mode);
        diff      = din ^ exp_raw;
        bad       = diff ^ chk_q.pol;
        idx_nx    = (chk_q.idx >= len) ? '0 : chk_q.idx + 1'b1;
        werrs_inc = chk_q.werrs + WE_W'(bad);
        if (active) begin
            if (!chk_q.locked) begin
                // hunting: self-seed from the received bits
                chk_d.lfsr = {chk_q.lfsr[LFSR_W-2:0], din};
                if (chk_q.run == '0 || !bad) begin
                    chk_d.pol = diff;
                    chk_d.run = chk_q.run + 1'b1;
                    chk_d.idx = idx_nx;
                    if (chk_q.run == RUN_W'(SYNC_RUN - 1)) begin
                        chk_d.locked = 1'b1;
                        chk_d.run    = '0;
                        chk_d.wbits  = '0;
                        chk_d.werrs  = '0;
                    end
                end else begin
                    // slip: hold the word index, restart the run
                    chk_d.run = '0;
                end
            end else begin
                // locked: free-run on the predicted bit
                chk_d.lfsr = {chk_q.lfsr[LFSR_W-2:0], exp_raw ^ chk_q.pol};
                chk_d.idx  = idx_nx;
                chk_d.bitc = chk_q.bitc + 1'b1;
                if (bad) chk_d.errc = chk_q.errc + 1'b1;
                if (werrs_inc >= WE_W'(LOSS_ERRS)) begin
                    chk_d.locked = 1'b0;
                    chk_d.run    = '0;
                    chk_d.wbits  = '0;
                    chk_d.werrs  = '0;
                end else if (chk_q.wbits == WB_W'(WIN_LEN - 1)) begin
                    chk_d.wbits = '0;
                    chk_d.werrs = '0;
                end else begin
                    chk_d.wbits = chk_q.wbits + 1'b1;
                    chk_d.werrs = werrs_inc;
                end
            end
        end
        chk_d.irq = chk_d.locked ^ chk_q.locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign sync     = chk_q.locked;
    assign inverted = chk_q.pol;
    assign irq      = chk_q.irq;
    assign err_cnt  = chk_q.errc;
    assign bit_cnt  = chk_q.bitc;

    AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chk_q.locked) || $fell(chk_q.locked)) |-> irq); // R8
    AST_HUNT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_q.locked |=> $stable(chk_q.bitc)); // R6
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (chk_q.errc == $past(chk_q.errc) || chk_q.errc == $past(chk_q.errc) + 1'b1)); // R5
    AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_q.locked) |-> $past(chk_q.run) == RUN_W'(SYNC_RUN - 1)); // R4
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q.werrs < WE_W'(LOSS_ERRS)); // R7

endmodule

// File: rtl/ts_prbs_unit.sv
module ts_prbs_unit #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    parameter int FIX_W     = 32,
    parameter int CNT_W     = 32,
    parameter int SYNC_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 6,
    localparam int LEN_W    = $clog2(FIX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [FIX_W-1:0] cfg_fixed,
    input  logic [LEN_W-1:0] cfg_fix_len,
    input  logic [SLOTS-1:0] cfg_slot_mask,
    input  logic             tx_fsync,
    input  logic             tx_in,
    output logic             tx_out,
    input  logic             rx_fsync,
    input  logic             rx_in,
    output logic             sync,
    output logic             sync_inv,
    output logic             sync_irq,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] bit_count
);

    logic tx_act;
    logic rx_act;

    ts_slot_track #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) i_tx_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .fsync  (tx_fsync),
        .mask   (cfg_slot_mask),
        .active (tx_act)
    );

    ts_slot_track #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) i_rx_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .fsync  (rx_fsync),
        .mask   (cfg_slot_mask),
        .active (rx_act)
    );

    ts_pattern_gen #(.FIX_W(FIX_W)) i_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (tx_act),
        .din    (tx_in),
        .mode   (cfg_mode),
        .fixed  (cfg_fixed),
        .len    (cfg_fix_len),
        .dout   (tx_out)
    );

    ts_pattern_chk #(
        .FIX_W     (FIX_W),
        .CNT_W     (CNT_W),
        .SYNC_RUN  (SYNC_RUN),
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS)
    ) i_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (rx_act),
        .din      (rx_in),
        .mode     (cfg_mode),
        .fixed    (cfg_fixed),
        .len      (cfg_fix_len),
        .sync     (sync),
        .inverted (sync_inv),
        .irq      (sync_irq),
        .err_cnt  (err_count),
        .bit_cnt  (bit_count)
    );

endmodule

// File: tb/test_ts_prbs_unit.sv
module test_ts_prbs_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [31:0] cfg_fixed = '0;
    logic [4:0]  cfg_fix_len = '0;
    logic [31:0] cfg_slot_mask = '0;
    logic        tx_fsync = 1'b0;
    logic        tx_in = 1'b0;
    logic        tx_out;
    logic        rx_fsync = 1'b0;
    logic        rx_in;
    logic        sync, sync_inv, sync_irq;
    logic [31:0] err_count, bit_count;
    logic        lb_inv = 1'b0;
    logic        flip = 1'b0;

    assign rx_in = tx_out ^ lb_inv ^ flip;

    ts_prbs_unit i_ts_prbs_unit (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fixed(cfg_fixed),
        .cfg_fix_len(cfg_fix_len), .cfg_slot_mask(cfg_slot_mask),
        .tx_fsync(tx_fsync), .tx_in(tx_in), .tx_out(tx_out),
        .rx_fsync(rx_fsync), .rx_in(rx_in), .sync(sync), .sync_inv(sync_inv),
        .sync_irq(sync_irq), .err_count(err_count), .bit_count(bit_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    int tpos = 255, rpos = 255, tidx = 0;
    logic [19:0] m_lfsr = '1;
    logic prev_fs = 1'b0;
    int act_n = 0, inj_n = 0, pend = 0, irq_n = 0;
    bit fell = 1'b0, done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step();
        bit fs, tact, ract, fl, ex, sy_b, fb;
        logic [31:0] bc_b;
        string tag;
        fs = (cyc % 256) == 0;
        tx_fsync = fs;
        rx_fsync = prev_fs;
        prev_fs  = fs;
        tx_in    = cyc[2] ^ cyc[5];
        tpos = fs ? 0 : (tpos + 1) % 256;
        tact = cfg_slot_mask[tpos / 8];
        if (!tact) begin
            ex = tx_in; tag = "R2";
        end else if (cfg_mode[1]) begin
            ex = cfg_fixed[tidx];
            tidx = (tidx >= int'(cfg_fix_len)) ? 0 : tidx + 1;
            tag = "R3";
        end else begin
            if (cfg_mode == 2'b01) begin
                if (m_lfsr == 0) m_lfsr = '1;
                fb = m_lfsr[19] ^ m_lfsr[16];
            end else begin
                if (m_lfsr[14:0] == 0) m_lfsr = '1;
                fb = m_lfsr[14] ^ m_lfsr[13];
            end
            m_lfsr = {m_lfsr[18:0], fb};
            ex = fb; tag = "R1";
        end
        rpos = rx_fsync ? 0 : (rpos + 1) % 256;
        ract = cfg_slot_mask[rpos / 8];
        fl = 1'b0;
        if (pend > 0 && ract && sync) begin
            fl = 1'b1; pend--; inj_n++;
        end
        flip = fl;
        if (ract) act_n++;
        bc_b = bit_count;
        sy_b = sync;
        cyc++;
        @(posedge clk);
        @(negedge clk);
        chk(tx_out == ex, tag, 32'(tx_out), 32'(ex));
        chk(sync_irq == (sync != sy_b), "R8", 32'(sync_irq), 32'(sync != sy_b));
        if (!sy_b) chk(bit_count == bc_b, "R6 hunt", bit_count, bc_b);
        if (sync_irq) irq_n++;
        if (sy_b && !sync) fell = 1'b1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic window(input int n, input int flips, input string tag);
        logic [31:0] bc0, ec0;
        int a0, i0;
        fell = 1'b0;
        bc0 = bit_count; ec0 = err_count; a0 = act_n; i0 = inj_n;
        for (int k = 0; k < flips; k++) begin
            pend = 1;
            run(n / (flips + 1));
        end
        run(n - flips * (n / (flips + 1)));
        chk(bit_count - bc0 == 32'(act_n - a0), {"R6 ", tag}, bit_count - bc0, 32'(act_n - a0));
        chk(err_count - ec0 == 32'(flips), {"R5 ", tag}, err_count - ec0, 32'(flips));
        chk(inj_n - i0 == flips, {"R5 inj ", tag}, 32'(inj_n - i0), 32'(flips));
        chk(sync && !fell, {"R7 keep ", tag}, 32'(sync), 32'd1);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(sync == 0 && sync_inv == 0 && sync_irq == 0, "R9 flags", {29'd0, sync, sync_inv, sync_irq}, 32'd0);
        chk(tx_out == 0, "R9 tx_out", 32'(tx_out), 32'd0);
        chk(err_count == 0 && bit_count == 0, "R9 counts", err_count | bit_count, 32'd0);
        rst_n = 1'b1;
        cfg_mode = 2'b00;
        cfg_slot_mask = 32'h0000_F00F;
        run(768);
        chk(sync == 1, "R4 short lock", 32'(sync), 32'd1);
        chk(sync_inv == 0, "R4 short polarity", 32'(sync_inv), 32'd0);
        chk(irq_n >= 1, "R8 pulse seen", 32'(irq_n), 32'd1);
        window(512, 3, "short");
        // burst of errors forces loss
        fell = 1'b0;
        pend = 14;
        run(256);
        chk(fell == 1, "R7 loss", 32'(fell), 32'd1);
        pend = 0;
        run(768);
        chk(sync == 1, "R4 relock", 32'(sync), 32'd1);
        // long sequence, inverted loopback
        cfg_mode = 2'b01;
        lb_inv = 1'b1;
        run(1024);
        chk(sync == 1 && sync_inv == 1, "R4 long inverted", {30'd0, sync, sync_inv}, 32'd3);
        window(256, 0, "long");
        // fixed 12-bit word on every slot
        cfg_mode = 2'b10;
        cfg_fixed = 32'h0000_000B;
        cfg_fix_len = 5'd11;
        cfg_slot_mask = 32'hFFFF_FFFF;
        lb_inv = 1'b0;
        run(1024);
        chk(sync == 1 && sync_inv == 0, "R3 word12 lock", {30'd0, sync, sync_inv}, 32'd2);
        window(256, 2, "word12");
        // full 32-bit word, inverted, upper slots
        cfg_fixed = 32'h1234_5678;
        cfg_fix_len = 5'd31;
        cfg_slot_mask = 32'hFFFF_0000;
        lb_inv = 1'b1;
        run(3072);
        chk(sync == 1 && sync_inv == 1, "R3 word32 inverted", {30'd0, sync, sync_inv}, 32'd3);
        window(512, 1, "word32");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule